// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block receives asynchronous serial frames on one input line. A baud generator outside the block supplies a strobe sixteen times per bit period. The block divides each bit into sixteen slices and, once the line has gone low, decides each bit by a two-of-three vote over three samples taken near the middle of the bit. A start bit that votes high is treated as noise: the receiver drops it and waits for the next falling edge.

Two frame shapes are selected by a mode input. The short frame has a start bit, eight data bits sent least significant bit first, and a stop bit. The long frame adds a ninth bit between the data and the stop bit. A received frame is moved into the output byte and extra-bit registers only when the completion flag is clear. When the address filter input is set, the frame is also kept only if its qualifying bit is 1: the stop bit in the short mode, the ninth bit in the long mode. Software-side logic clears the completion flag with a one-cycle strobe.

Top module: `vote_uart_rx`

## Requirements
- R1: After reset, rx_done, rx_byte and rx_bit8 are all 0.
- R2: A frame starts on a baud tick that samples the synchronized line at 0 when the previous tick sampled 1. That tick is slice 0. Each bit value is the majority of the line samples at slices 8, 9 and 10 of that bit.
- R3: If the start bit votes 1, the frame is abandoned without any change to the outputs, and a later falling edge starts a new frame normally.
- R4: The eight data bits are received least significant bit first and appear in rx_byte.
- R5: With mode9 = 0 (10-bit frame), rx_bit8 receives the voted stop bit.
- R6: With mode9 = 1 (11-bit frame), rx_bit8 receives the voted ninth bit.
- R7: A frame that completes while rx_done = 1 leaves rx_byte and rx_bit8 unchanged and leaves rx_done at 1.
- R8: With mp_filter = 1, a frame is kept only if its qualifying bit is 1: the stop bit when mode9 = 0, the ninth bit when mode9 = 1. Otherwise it is discarded.
- R9: rx_done stays at 1 until flag_clr is high on a clock edge. If a frame completes in the same cycle as flag_clr, the frame is kept only if rx_done was 0, and rx_done ends at 1 if the frame was kept and at 0 if it was not.
- R10: The receiver is looking for a new falling edge again from the tick after slice 10 of the stop bit. A frame whose start bit begins at slice 11 of the previous stop bit is received.
- R11: The slice counter and frame state change only on clock edges where tick16 is high. Any number of clocks between ticks gives the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tick16 | input | 1 | One-cycle strobe at sixteen times the bit rate |
| mode9 | input | 1 | 0: 10-bit frame, 1: 11-bit frame with ninth bit |
| mp_filter | input | 1 | Address filter enable |
| flag_clr | input | 1 | Strobe that clears rx_done |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit8 | output | 1 | Stop bit (10-bit mode) or ninth bit (11-bit mode) of the last accepted frame |
| rx_done | output | 1 | Frame-received flag |

## Verification
A frame completing on the vote tick of its last bit can fall in the same clock cycle as the flag_clr strobe. These two functions compete for rx_done and for the output registers. The bench provokes this by raising flag_clr on exactly the tick that carries slice 10 of the last bit. It does this once with rx_done already set, where the frame must be dropped and the flag must end low, and once with rx_done clear, where the frame must be kept and the flag must end high. rx_byte and rx_bit8 are compared against the expected values in both cases.

// File: rtl/vrx_pkg.sv
package vrx_pkg;

    localparam int RX_DATA_W  = 8;
    localparam int RX_SLICES  = 16;
    localparam int RX_SLICE_W = $clog2(RX_SLICES);

    typedef enum logic [0:0] {
        FR_IDLE = 1'b0,
        FR_BUSY = 1'b1
    } fr_state_e;

    typedef struct packed {
        logic [RX_DATA_W-1:0] data;
        logic                 bit8;
    } rx_frame_t;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic int unsigned last_bit_idx(input logic long_frame);
        return long_frame ? RX_DATA_W + 2 : RX_DATA_W + 1;
    endfunction

endpackage

// File: rtl/vrx_sync.sv
module vrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/vrx_slicer.sv
module vrx_slicer
    import vrx_pkg::*;
#(
    parameter int SLICES  = RX_SLICES,
    parameter int VOTE_AT = SLICES / 2,
    localparam int SW     = $clog2(SLICES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          start,
    input  logic          busy,
    input  logic          line,
    output logic [SW-1:0] slice,
    output logic          bit_done,
    output logic          bit_val
);
    logic [SW-1:0] cnt;
    logic [SW-1:0] nxt;
    logic [1:0]    early;

    // Next slice index, wrapping after the last slice of a bit.
    assign nxt = (cnt == SW'(SLICES - 1)) ? '0 : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            early <= '0;
        end else if (tick) begin
            if (start) begin
                cnt <= '0;
            end else if (busy) begin
                cnt <= nxt;
                if (nxt == SW'(VOTE_AT))     early[0] <= line;
                if (nxt == SW'(VOTE_AT + 1)) early[1] <= line;
            end
        end
    end

    // Third vote sample is the live line on the deciding tick.
    assign bit_done = tick & busy & ~start & (nxt == SW'(VOTE_AT + 2));
    assign bit_val  = maj3({early, line});
    assign slice    = cnt;
endmodule

// File: rtl/vrx_framer.sv
module vrx_framer
    import vrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  logic      mode9,
    input  logic      bit_done,
    input  logic      bit_val,
    output logic      busy,
    output logic      start,
    output logic      frame_done,
    output rx_frame_t frm
);
    localparam int DW = RX_DATA_W;
    localparam int IW = $clog2(DW + 3);

    fr_state_e         state;
    logic [IW-1:0]     idx;
    logic [IW-1:0]     fin_idx;
    logic [DW-1:0]     shreg;
    logic              ninth;
    logic              last;

    assign fin_idx    = IW'(last_bit_idx(mode9));
    assign busy       = (state == FR_BUSY);
    assign start      = tick & (state == FR_IDLE) & last & ~line;
    assign frame_done = bit_done & busy & (idx == fin_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FR_IDLE;
            idx   <= '0;
            shreg <= '0;
            ninth <= 1'b0;
            last  <= 1'b1;
        end else begin
            case (state)
                FR_IDLE: begin
                    if (tick) begin
                        last <= line;
                        if (start) begin
                            state <= FR_BUSY;
                            idx   <= '0;
                        end
                    end
                end
                FR_BUSY: begin
                    if (bit_done) begin
                        idx <= idx + 1'b1;
                        if (idx == '0) begin
                            if (bit_val) begin
                                state <= FR_IDLE;
                                last  <= line;
                            end
                        end else if (idx == fin_idx) begin
                            state <= FR_IDLE;
                            last  <= line;
                        end else if (idx <= IW'(DW)) begin
                            shreg <= {bit_val, shreg[DW-1:1]};
                        end else begin
                            ninth <= bit_val;
                        end
                    end
                end
                default: state <= FR_IDLE;
            endcase
        end
    end

    assign frm.data = shreg;
    assign frm.bit8 = mode9 ? ninth : bit_val;
endmodule

// File: rtl/vrx_commit.sv
module vrx_commit
    import vrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_done,
    input  rx_frame_t            frm,
    input  logic                 mp_filter,
    input  logic                 flag_clr,
    output logic [RX_DATA_W-1:0] rx_byte,
    output logic                 rx_bit8,
    output logic                 rx_done
);
    logic accept;

    // The qualifying bit for the filter is the bit that lands in rx_bit8.
    assign accept = frame_done & ~rx_done & (~mp_filter | frm.bit8);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
            rx_bit8 <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            if (accept) begin
                rx_byte <= frm.data;
                rx_bit8 <= frm.bit8;
            end
            rx_done <= accept | (rx_done & ~flag_clr);
        end
    end
endmodule

// File: rtl/vote_uart_rx.sv
module vote_uart_rx
    import vrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    input  logic                 tick16,
    input  logic                 mode9,
    input  logic                 mp_filter,
    input  logic                 flag_clr,
    output logic [RX_DATA_W-1:0] rx_byte,
    output logic                 rx_bit8,
    output logic                 rx_done
);
    logic                  line_s;
    logic                  busy;
    logic                  start;
    logic                  bit_done;
    logic                  bit_val;
    logic                  frame_done;
    logic [RX_SLICE_W-1:0] slice;
    rx_frame_t             frm;

    vrx_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_s)
    );

    vrx_slicer #(.SLICES(RX_SLICES)) u_slicer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .start    (start),
        .busy     (busy),
        .line     (line_s),
        .slice    (slice),
        .bit_done (bit_done),
        .bit_val  (bit_val)
    );

    vrx_framer u_framer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick16),
        .line       (line_s),
        .mode9      (mode9),
        .bit_done   (bit_done),
        .bit_val    (bit_val),
        .busy       (busy),
        .start      (start),
        .frame_done (frame_done),
        .frm        (frm)
    );

    vrx_commit u_commit (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .frm        (frm),
        .mp_filter  (mp_filter),
        .flag_clr   (flag_clr),
        .rx_byte    (rx_byte),
        .rx_bit8    (rx_bit8),
        .rx_done    (rx_done)
    );
endmodule

// File: rtl/vrx_checker.sv
module vrx_checker
    import vrx_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  tick16,
    input logic                  flag_clr,
    input logic                  rx_done,
    input logic [RX_DATA_W-1:0]  rx_byte,
    input logic                  rx_bit8,
    input logic                  busy,
    input logic [RX_SLICE_W-1:0] slice
);
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !flag_clr) |=> rx_done);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !tick16) |=> !rx_done);

    assert_buffer_locked_R7: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> ($stable(rx_byte) && $stable(rx_bit8)));

    assert_tick_gated_R11: assert property (@(posedge clk) disable iff (rst)
        !tick16 |=> ($stable(slice) && $stable(busy)));

    assert_commit_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> $past(tick16));

    assert_start_resets_slice_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (slice == '0));
endmodule

bind vote_uart_rx vrx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick16   (tick16),
    .flag_clr (flag_clr),
    .rx_done  (rx_done),
    .rx_byte  (rx_byte),
    .rx_bit8  (rx_bit8),
    .busy     (busy),
    .slice    (slice)
);

// File: tb/sim_vote_uart_rx.sv
`timescale 1ns/1ps
module sim_vote_uart_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       tick16 = 1'b0;
    logic       mode9 = 1'b0;
    logic       mp_filter = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit8;
    logic       rx_done;

    int tests = 0;
    int fails = 0;
    int gap = 3;

    // Expected state of the outputs.
    logic       ri_m = 1'b0;
    logic [7:0] byte_m = 8'h00;
    logic       b8_m = 1'b0;

    int gin [0:10];
    int gout [0:10];

    always #2.5 clk = ~clk;

    vote_uart_rx u0 (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .tick16    (tick16),
        .mode9     (mode9),
        .mp_filter (mp_filter),
        .flag_clr  (flag_clr),
        .rx_byte   (rx_byte),
        .rx_bit8   (rx_bit8),
        .rx_done   (rx_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One baud tick: set the line, let it settle through the synchronizer, pulse tick.
    task automatic step(input logic v, input logic clr);
        @(negedge clk);
        rx_line = v;
        repeat (gap - 1) @(negedge clk);
        tick16   = 1'b1;
        flag_clr = clr;
        @(negedge clk);
        tick16   = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic idle(input int n, input logic clr);
        for (int i = 0; i < n; i++) step(1'b1, clr && (i == 0));
        if (clr) ri_m = 1'b0;
    endtask

    task automatic no_glitch();
        for (int k = 0; k < 11; k++) begin
            gin[k]  = -1;
            gout[k] = -1;
        end
    endtask

    task automatic rand_glitch();
        for (int k = 0; k < 11; k++) begin
            int r;
            gin[k] = ($urandom % 2 == 0) ? 8 + int'($urandom % 3) : -1;
            r = int'($urandom % 12);
            gout[k] = ($urandom % 2 == 0) ? ((r < 7) ? r + 1 : r + 4) : -1;
        end
    endtask

    // Sends a frame up to slice 10 of its last bit, then updates the model.
    task automatic send(input logic m9, input logic mp, input logic [7:0] d,
                        input logic b9, input logic stp, input logic clr_last);
        logic bits [0:10];
        int   lastb;
        int   nt;
        logic b8;
        logic acc;
        mode9     = m9;
        mp_filter = mp;
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[i+1] = d[i];
        bits[9]  = m9 ? b9 : stp;
        bits[10] = stp;
        lastb = m9 ? 10 : 9;
        nt = 16 * lastb + 11;
        for (int j = 0; j < nt; j++) begin
            int   k = j / 16;
            int   s = j % 16;
            logic v = bits[k];
            if (s == gin[k])  v = ~v;
            if (s == gout[k]) v = ~v;
            step(v, clr_last && (j == nt - 1));
        end
        b8  = m9 ? b9 : stp;
        acc = !ri_m && (!mp || b8);
        if (acc) begin
            byte_m = d;
            b8_m   = b8;
        end
        ri_m = acc | (ri_m & ~clr_last);
    endtask

    task automatic check_out(input string tag);
        chk({tag, " rx_done"}, {31'b0, rx_done}, {31'b0, ri_m});
        chk({tag, " rx_byte"}, {24'b0, rx_byte}, {24'b0, byte_m});
        chk({tag, " rx_bit8"}, {31'b0, rx_bit8}, {31'b0, b8_m});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0a11));
        no_glitch();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_out("R1 reset");
        idle(4, 1'b0);

        // R2 R4 R5: plain 10-bit frame
        send(1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0);
        check_out("R2 R4 R5 basic");
        idle(3, 1'b0);

        // R7: frame while flag set is lost
        send(1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0);
        check_out("R7 flag set");
        idle(3, 1'b1);
        check_out("R9 clear");

        // R3: false start, low for slices 0..3
        for (int j = 0; j < 4; j++) step(1'b0, 1'b0);
        idle(30, 1'b0);
        check_out("R3 false start short");
        // R3: votes 0,1,1 at slices 8,9,10
        for (int j = 0; j < 9; j++) step(1'b0, 1'b0);
        idle(30, 1'b0);
        check_out("R3 false start vote");
        send(1'b0, 1'b0, 8'h96, 1'b0, 1'b1, 1'b0);
        check_out("R3 after abort");
        idle(3, 1'b1);

        // R6 R8: 11-bit address frame with filter on
        send(1'b1, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b0);
        check_out("R6 R8 address kept");
        idle(3, 1'b1);
        send(1'b1, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b0);
        check_out("R8 data frame dropped");
        idle(3, 1'b0);
        send(1'b0, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0);
        check_out("R8 bad stop dropped");
        idle(3, 1'b0);
        send(1'b0, 1'b0, 8'hF0, 1'b0, 1'b0, 1'b0);
        check_out("R5 stop zero kept");
        idle(3, 1'b0);

        // R9: clear strobe on the completion tick
        send(1'b0, 1'b0, 8'h81, 1'b0, 1'b1, 1'b1);
        check_out("R9 collision flag set");
        idle(3, 1'b0);
        send(1'b0, 1'b0, 8'h7E, 1'b0, 1'b1, 1'b1);
        check_out("R9 collision flag clear");
        idle(3, 1'b1);

        // R10: next start bit right after slice 10 of the stop bit
        send(1'b1, 1'b1, 8'h22, 1'b0, 1'b1, 1'b0);
        send(1'b1, 1'b1, 8'hB4, 1'b1, 1'b1, 1'b0);
        check_out("R10 back to back");
        idle(3, 1'b1);

        // R11: long gaps between ticks
        gap = 9;
        send(1'b0, 1'b0, 8'h6D, 1'b0, 1'b1, 1'b0);
        check_out("R11 slow ticks");
        gap = 3;
        idle(3, 1'b1);

        // Random frames with glitches inside and outside the vote window.
        for (int n = 0; n < 40; n++) begin
            logic m9  = 1'($urandom % 2);
            logic mp  = 1'($urandom % 2);
            logic [7:0] d = 8'($urandom);
            logic b9  = 1'($urandom % 2);
            logic stp = ($urandom % 8) != 0;
            gap = 3 + int'($urandom % 4);
            if ($urandom % 10 < 6) idle(2, 1'b1);
            rand_glitch();
            send(m9, mp, d, b9, stp, 1'b0);
            no_glitch();
            check_out(m9 ? "R2 R6 R8 random" : "R2 R4 R5 random");
            idle(3, 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule